// File: doc/BRIEF.md
# Retrace-Synchronised Display Control Registers

This block holds the software-visible display controls of a colour frame buffer. It has a one-cycle register write port and a combinational read port. It takes a vertical-retrace level from the video timing generator and drives the display-side controls: video enable, display and read bank selects, per-bank write inhibits, a colour-map copy strobe with its direction, a shadow-map write block and an interrupt request.

Some controls take effect when written. Others are held as requests and applied only on a retrace rising edge, so the screen never changes in the middle of a frame. These are the display bank, the colour-map transfer direction and the colour-map copy. A three-state wait machine lets software block until one whole retrace interval has passed since its write. States: `W_IDLE` (bit reads 0), `W_ARMED` (waiting for a retrace rise) and `W_HOLD` (inside the retrace, waiting for its fall). Transitions: `W_IDLE`→`W_ARMED` on a write of 1 to the wait bit, `W_ARMED`→`W_HOLD` on a retrace rise, `W_HOLD`→`W_IDLE` on a retrace fall. Every other event holds the state.

The retrace input is registered once. A rise means the current sample is high and the previous sample was low; a fall is the reverse. All state updates on a detected edge happen at the same clock edge that sees the new sample.

Top module: `disp_ctl_regs`

## Requirements
- R1: After reset every output is 0, every readable field is 0 and the frame count is 0.
- R2: Select 0 (control word) bit 5 reads the retrace input as sampled at the previous clock edge. Select 3 always reads 0.
- R3: Control bit 2 enables the interrupt. On a retrace fall with the enable set, the pending flag (control bit 4, read-only) sets and `irq` follows it from the next cycle.
- R4: A control write with bit 2 = 0 or bit 3 = 1 clears the pending flag. Bit 3 always reads 0. If a set and a clear meet in one cycle, the set wins.
- R5: Control bit 1 requests a colour-map copy and drives `shadow_wr_block` while it is set. On a retrace rise with the bit set, `cmap_copy` pulses for exactly one cycle and the bit clears, unless a write in that cycle gives it a new value.
- R6: Bank word (select 1) bit 0 (display bank B) and bit 4 (reverse transfer direction) are stored requests. They reach `show_bank_b` and `cmap_dir_rev` only on a retrace rise, and they read back the request.
- R7: Bank word bit 1 drives `read_bank_b`, bit 2 drives `inhibit_a` and bit 3 drives `inhibit_b` from the cycle after the write.
- R8: Bank word bit 5 is the wait bit. Writing 1 sets it, writing 0 has no effect, and it reads 1 until the fall of the first retrace whose rise comes after the write. A retrace rise in the same cycle as the write, or a retrace already under way, does not count.
- R9: Select 2 reads an 8-bit frame count. It increments on each retrace rise and wraps from 255 to 0.
- R10: Control bit 0 drives `video_en` from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_sel | input | 2 | Register select: 0 control, 1 bank, 2 frame count |
| reg_wdata | input | 6 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| vretrace_in | input | 1 | Vertical retrace level |
| irq | output | 1 | Interrupt request (pending flag) |
| show_bank_b | output | 1 | Applied display bank, 1 = B |
| read_bank_b | output | 1 | Bank used for reads, 1 = B |
| inhibit_a | output | 1 | Block writes to bank A |
| inhibit_b | output | 1 | Block writes to bank B |
| cmap_copy | output | 1 | One-cycle colour-map copy strobe |
| cmap_dir_rev | output | 1 | Applied colour-map transfer direction |
| shadow_wr_block | output | 1 | Blocks writes to the shadow colour map |
| video_en | output | 1 | Video output enable |

## Verification
The bench builds the block with its default widths: a 6-bit write field and an 8-bit read and frame-count width. At these widths the frame-count wrap can be reached within a few hundred short retrace pulses. A behavioural model runs alongside the design and is compared on every clock. The stimulus places writes on the same cycle as retrace edges to exercise the set-over-clear rule, a write that overrides a pending copy, and a wait request that begins during a retrace.

// File: rtl/disp_pkg.sv
package disp_pkg;
    localparam int unsigned FIELD_W = 6;
    localparam int unsigned SEL_W   = 2;

    localparam logic [SEL_W-1:0] SEL_CTRL  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_BANK  = 2'd1;
    localparam logic [SEL_W-1:0] SEL_FRAME = 2'd2;

    // control word fields
    localparam int unsigned C_VIDEO = 0;
    localparam int unsigned C_UPD   = 1;
    localparam int unsigned C_IEN   = 2;
    localparam int unsigned C_ACK   = 3;
    localparam int unsigned C_PEND  = 4;
    localparam int unsigned C_VRT   = 5;

    // bank word fields
    localparam int unsigned B_DISP  = 0;
    localparam int unsigned B_READ  = 1;
    localparam int unsigned B_INHA  = 2;
    localparam int unsigned B_INHB  = 3;
    localparam int unsigned B_DIR   = 4;
    localparam int unsigned B_WAIT  = 5;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_ARMED = 2'd1,
        W_HOLD  = 2'd2
    } wait_st_t;
endpackage

// File: rtl/disp_retrace_edge.sv
module disp_retrace_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic vr_in,
    output logic vr_q,
    output logic rise,
    output logic fall
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vr_q <= 1'b0;
        else        vr_q <= vr_in;
    end

    always_comb begin
        rise = vr_in & ~vr_q;
        fall = ~vr_in & vr_q;
    end
endmodule

// File: rtl/disp_wait_fsm.sv
module disp_wait_fsm
    import disp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic rise,
    input  logic fall,
    output logic busy
);
    wait_st_t st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= W_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            W_IDLE:  if (set_req) st_nx = W_ARMED;
            W_ARMED: if (rise)    st_nx = W_HOLD;
            W_HOLD:  if (fall)    st_nx = W_IDLE;
            default:              st_nx = W_IDLE;
        endcase
    end

    always_comb begin
        busy = (st != W_IDLE);
    end
endmodule

// File: rtl/disp_frame_ctr.sv
module disp_frame_ctr #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (step) count <= count + 1'b1;
    end
endmodule

// File: rtl/disp_ctl_regs.sv
module disp_ctl_regs
    import disp_pkg::*;
#(
    parameter int unsigned RD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [SEL_W-1:0]   reg_sel,
    input  logic [FIELD_W-1:0] reg_wdata,
    output logic [RD_W-1:0]    reg_rdata,
    input  logic               vretrace_in,
    output logic               irq,
    output logic               show_bank_b,
    output logic               read_bank_b,
    output logic               inhibit_a,
    output logic               inhibit_b,
    output logic               cmap_copy,
    output logic               cmap_dir_rev,
    output logic               shadow_wr_block,
    output logic               video_en
);
    localparam int unsigned PAD_W = RD_W - FIELD_W;

    logic vr_q, rise, fall;
    logic wr_ctrl, wr_bank;
    logic upd_q, ien_q, pend_q;
    logic disp_req_q, dir_req_q;
    logic wait_busy;
    logic [RD_W-1:0] frame_cnt;
    logic pend_set, pend_clr;

    disp_retrace_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .vr_in (vretrace_in),
        .vr_q  (vr_q),
        .rise  (rise),
        .fall  (fall)
    );

    disp_wait_fsm u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (wr_bank & reg_wdata[B_WAIT]),
        .rise    (rise),
        .fall    (fall),
        .busy    (wait_busy)
    );

    disp_frame_ctr #(.CNT_W(RD_W)) u_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (rise),
        .count (frame_cnt)
    );

    always_comb begin
        wr_ctrl  = reg_wr && (reg_sel == SEL_CTRL);
        wr_bank  = reg_wr && (reg_sel == SEL_BANK);
        pend_set = fall && ien_q;
        pend_clr = wr_ctrl && (!reg_wdata[C_IEN] || reg_wdata[C_ACK]);
    end

    // control word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            video_en <= 1'b0;
            ien_q    <= 1'b0;
            upd_q    <= 1'b0;
        end else if (wr_ctrl) begin
            video_en <= reg_wdata[C_VIDEO];
            ien_q    <= reg_wdata[C_IEN];
            upd_q    <= reg_wdata[C_UPD];
        end else if (rise) begin
            upd_q    <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (pend_set) pend_q <= 1'b1;
        else if (pend_clr) pend_q <= 1'b0;
    end

    // bank word, immediate fields and stored requests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            read_bank_b <= 1'b0;
            inhibit_a   <= 1'b0;
            inhibit_b   <= 1'b0;
            disp_req_q  <= 1'b0;
            dir_req_q   <= 1'b0;
        end else if (wr_bank) begin
            read_bank_b <= reg_wdata[B_READ];
            inhibit_a   <= reg_wdata[B_INHA];
            inhibit_b   <= reg_wdata[B_INHB];
            disp_req_q  <= reg_wdata[B_DISP];
            dir_req_q   <= reg_wdata[B_DIR];
        end
    end

    // retrace-applied state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            show_bank_b  <= 1'b0;
            cmap_dir_rev <= 1'b0;
            cmap_copy    <= 1'b0;
        end else begin
            cmap_copy <= rise & upd_q;
            if (rise) begin
                show_bank_b  <= disp_req_q;
                cmap_dir_rev <= dir_req_q;
            end
        end
    end

    always_comb begin
        irq             = pend_q;
        shadow_wr_block = upd_q;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_CTRL:  reg_rdata = {{PAD_W{1'b0}}, vr_q, pend_q, 1'b0,
                                   ien_q, upd_q, video_en};
            SEL_BANK:  reg_rdata = {{PAD_W{1'b0}}, wait_busy, dir_req_q,
                                   inhibit_b, inhibit_a, read_bank_b, disp_req_q};
            SEL_FRAME: reg_rdata = frame_cnt;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/disp_ctl_regs_chk.sv
module disp_ctl_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [1:0] reg_sel,
    input logic [7:0] reg_rdata,
    input logic       vretrace_in,
    input logic       irq,
    input logic       show_bank_b,
    input logic       inhibit_a,
    input logic       cmap_copy,
    input logic       cmap_dir_rev
);
    assert_copy_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmap_copy |=> !cmap_copy);

    assert_irq_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (!$past(vretrace_in) && $past(vretrace_in, 2)));

    assert_bank_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(show_bank_b) |-> ($past(vretrace_in) && !$past(vretrace_in, 2)));

    assert_dir_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmap_dir_rev) |-> ($past(vretrace_in) && !$past(vretrace_in, 2)));

    assert_inhibit_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(inhibit_a) |-> ($past(reg_wr) && $past(reg_sel) == 2'd1));

    assert_frame_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vretrace_in) && reg_sel == 2'd2) |=>
        (reg_sel != 2'd2 || reg_rdata == $past(reg_rdata) + 8'd1));
endmodule

bind disp_ctl_regs disp_ctl_regs_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_sel      (reg_sel),
    .reg_rdata    (reg_rdata),
    .vretrace_in  (vretrace_in),
    .irq          (irq),
    .show_bank_b  (show_bank_b),
    .inhibit_a    (inhibit_a),
    .cmap_copy    (cmap_copy),
    .cmap_dir_rev (cmap_dir_rev)
);

// File: tb/sim_disp_ctl_regs.sv
`timescale 1ns/1ps
module sim_disp_ctl_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [5:0] reg_wdata = 6'd0;
    logic [7:0] reg_rdata;
    logic       vretrace_in = 1'b0;
    logic irq, show_bank_b, read_bank_b, inhibit_a, inhibit_b;
    logic cmap_copy, cmap_dir_rev, shadow_wr_block, video_en;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    disp_ctl_regs u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vretrace_in(vretrace_in),
        .irq(irq), .show_bank_b(show_bank_b), .read_bank_b(read_bank_b),
        .inhibit_a(inhibit_a), .inhibit_b(inhibit_b), .cmap_copy(cmap_copy),
        .cmap_dir_rev(cmap_dir_rev), .shadow_wr_block(shadow_wr_block),
        .video_en(video_en)
    );

    // behavioural reference
    bit m_vrq, m_vid, m_upd, m_ien, m_pend, m_dreq, m_disp, m_rdb;
    bit m_ina, m_inb, m_rreq, m_dir, m_copy;
    int m_wait;   // 0 idle, 1 waiting for rise, 2 waiting for fall
    int m_fc;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_vrq = 0; m_vid = 0; m_upd = 0; m_ien = 0; m_pend = 0;
            m_dreq = 0; m_disp = 0; m_rdb = 0; m_ina = 0; m_inb = 0;
            m_rreq = 0; m_dir = 0; m_copy = 0; m_wait = 0; m_fc = 0;
        end else begin
            bit rise, fall, w0, w1, setp, clrp;
            rise = vretrace_in && !m_vrq;
            fall = !vretrace_in && m_vrq;
            w0 = reg_wr && reg_sel == 2'd0;
            w1 = reg_wr && reg_sel == 2'd1;
            m_copy = rise && m_upd;
            setp = fall && m_ien;
            clrp = w0 && (!reg_wdata[2] || reg_wdata[3]);
            if (rise) begin
                m_disp = m_dreq; m_dir = m_rreq; m_fc = (m_fc + 1) % 256;
            end
            if (setp) m_pend = 1; else if (clrp) m_pend = 0;
            if (w0) begin
                m_vid = reg_wdata[0]; m_upd = reg_wdata[1]; m_ien = reg_wdata[2];
            end else if (rise) m_upd = 0;
            if (m_wait == 0) begin
                if (w1 && reg_wdata[5]) m_wait = 1;
            end else if (m_wait == 1) begin
                if (rise) m_wait = 2;
            end else if (fall) m_wait = 0;
            if (w1) begin
                m_dreq = reg_wdata[0]; m_rdb = reg_wdata[1]; m_ina = reg_wdata[2];
                m_inb = reg_wdata[3]; m_rreq = reg_wdata[4];
            end
            m_vrq = vretrace_in;
        end
    end

    function automatic logic [7:0] m_rd(input logic [1:0] s);
        case (s)
            2'd0: m_rd = {2'b0, m_vrq, m_pend, 1'b0, m_ien, m_upd, m_vid};
            2'd1: m_rd = {2'b0, (m_wait != 0), m_rreq, m_inb, m_ina, m_rdb, m_dreq};
            2'd2: m_rd = m_fc[7:0];
            default: m_rd = 8'd0;
        endcase
    endfunction

    task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cmp("R3 irq", {7'b0, irq}, {7'b0, m_pend});
        cmp("R6 show_bank_b", {7'b0, show_bank_b}, {7'b0, m_disp});
        cmp("R6 cmap_dir_rev", {7'b0, cmap_dir_rev}, {7'b0, m_dir});
        cmp("R7 read/inhibit", {5'b0, read_bank_b, inhibit_a, inhibit_b},
            {5'b0, m_rdb, m_ina, m_inb});
        cmp("R5 cmap_copy", {7'b0, cmap_copy}, {7'b0, m_copy});
        cmp("R5 shadow_wr_block", {7'b0, shadow_wr_block}, {7'b0, m_upd});
        cmp("R10 video_en", {7'b0, video_en}, {7'b0, m_vid});
        if (reg_sel == 2'd1)      cmp("R8 bank word", reg_rdata, m_rd(reg_sel));
        else if (reg_sel == 2'd2) cmp("R9 frame count", reg_rdata, m_rd(reg_sel));
        else                      cmp("R2 control word", reg_rdata, m_rd(reg_sel));
    endtask

    task automatic wr(input logic [1:0] s, input logic [5:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic look(input logic [1:0] s, input int n);
        reg_sel = s;
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic vr(input logic v);
        vretrace_in = v;
        tick();
    endtask

    task automatic frame(input int lo, input int hi);
        vretrace_in = 1'b1;
        for (int i = 0; i < hi; i++) tick();
        vretrace_in = 1'b0;
        for (int i = 0; i < lo; i++) tick();
    endtask

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of every register
        cmp("R1 ctrl", reg_rdata, 8'd0);
        rst_n = 1'b1;
        look(2'd1, 2); look(2'd2, 2); look(2'd3, 2); look(2'd0, 2);

        // R10 and R2
        wr(2'd0, 6'b000001);
        look(2'd0, 2);
        frame(3, 3);

        // R3/R4: interrupt on fall, ack, disable
        wr(2'd0, 6'b000101);
        frame(3, 4);
        cmp("R3 irq raised", {7'b0, irq}, 8'd1);
        wr(2'd0, 6'b001101);
        cmp("R4 irq acked", {7'b0, irq}, 8'd0);
        frame(3, 4);
        wr(2'd0, 6'b000001);
        cmp("R4 irq cleared by disable", {7'b0, irq}, 8'd0);
        // R4: set wins over same-cycle clear
        wr(2'd0, 6'b000101);
        vretrace_in = 1'b1; tick(); tick();
        vretrace_in = 1'b0; reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 6'b001101;
        tick(); reg_wr = 1'b0;
        cmp("R4 set beats clear", {7'b0, irq}, 8'd1);
        wr(2'd0, 6'b000001);

        // R5: colour-map copy
        wr(2'd0, 6'b000011);
        look(2'd0, 3);
        frame(4, 3);
        cmp("R5 upd bit cleared", {7'b0, shadow_wr_block}, 8'd0);
        // R5: write during the rise overrides the clear
        wr(2'd0, 6'b000011);
        vretrace_in = 1'b1; reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 6'b000011;
        tick(); reg_wr = 1'b0;
        tick(); tick(); vr(1'b0); look(2'd0, 2);
        frame(3, 3);

        // R6/R7: bank controls
        wr(2'd1, 6'b011111);
        look(2'd1, 3);
        cmp("R6 bank not yet applied", {7'b0, show_bank_b}, 8'd0);
        frame(3, 3);
        cmp("R6 bank applied", {7'b0, show_bank_b}, 8'd1);
        wr(2'd1, 6'b000010);
        frame(3, 3);

        // R8: wait bit
        wr(2'd1, 6'b100000);
        look(2'd1, 3);
        frame(3, 4);
        cmp("R8 wait cleared", reg_rdata & 8'h20, 8'h00);
        // request while a retrace is in progress: that one does not count
        vr(1'b1); tick();
        wr(2'd1, 6'b100000);
        tick(); vr(1'b0); look(2'd1, 2);
        cmp("R8 wait still set", reg_rdata & 8'h20, 8'h20);
        frame(3, 3);
        // write on the rise cycle, then a write of 0 while busy
        vretrace_in = 1'b1; reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 6'b100000;
        tick(); reg_wr = 1'b0;
        tick(); vr(1'b0);
        wr(2'd1, 6'b000000);
        look(2'd1, 2);
        frame(3, 3);
        look(2'd1, 2);

        // R9: frame counter wrap
        reg_sel = 2'd2;
        for (int i = 0; i < 260; i++) frame(1, 1);
        look(2'd2, 2);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule